// File: doc/BRIEF.md
# IPv4 Header Check and Update

This block takes an IPv4 header as a stream of 32-bit words, one word per valid cycle, with a marker on the final word. A counter tracks each word's position, and each position goes to its own check. Word 0 carries the version and the header length. Word 2 carries the time-to-live and the header checksum. Word 4 is the destination address, which goes to a route lookup stage as soon as it arrives. If any single check fails anywhere in the header, the whole packet is marked for discard.

A running one's-complement sum of all 16-bit halves is kept while the words arrive. The verdict therefore comes one cycle after the last word, whatever the header length. At the same time the block prepares the values a header rebuild stage needs. These are the decremented time-to-live and the incrementally updated checksum. Every word whose content does not change is also sent on as a stream, so that a store can keep it.

Top module: `ipv4_hdr_check`

## Requirements
- R1: Word indexing. The first valid word after reset, or after a word marked last, has index 0. The index advances by one for each valid word.
- R2: The version is bits [31:28] of word 0. A value other than 4 makes the packet a drop.
- R3: The header length in words is bits [27:24] of word 0. The packet is a drop if this length is below 5, if it differs from the number of words received, or if more than 15 words arrive.
- R4: The time-to-live is bits [31:24] of word 2. `new_ttl` takes that value minus one in the cycle after word 2 and holds it until the next word 2. An incoming value of 0 or 1 makes the packet a drop.
- R5: The packet is a drop unless the one's-complement sum of all 16-bit halves of all its words, with end-around carries, equals 0xFFFF.
- R6: `new_csum` is the received checksum (bits [15:0] of word 2) plus 0x0100 in one's-complement arithmetic with the end-around carry. It appears in the cycle after word 2 and holds until the next word 2.
- R7: `dst_addr` takes the value of word 4, and `dst_valid` pulses for exactly one cycle in the cycle after word 4.
- R8: In the cycle after a word marked last, exactly one of `fwd` or `drop` pulses for one cycle. `fwd` pulses only when none of R2 to R5 failed. Neither pulses at any other time.
- R9: Every valid word except index 2 appears on `keep_data` with `keep_valid` high in the cycle after it arrives. Word 2 is never emitted.
- R10: While reset is active and in the first cycle after it, all outputs are zero.
- R11: Idle cycles with `in_valid` low between words of a header do not advance the index and do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header word present |
| in_data | input | 32 | Header word |
| in_last | input | 1 | Final word of the header |
| fwd | output | 1 | One-cycle pulse: packet passes all checks |
| drop | output | 1 | One-cycle pulse: packet failed a check |
| new_ttl | output | 8 | Decremented time-to-live |
| new_csum | output | 16 | Updated header checksum |
| dst_addr | output | 32 | Destination address for route lookup |
| dst_valid | output | 1 | One-cycle strobe for `dst_addr` |
| keep_valid | output | 1 | Unchanged word present |
| keep_data | output | 32 | Unchanged header word |

## Verification
The assertions assume that `in_last` is only ever seen together with `in_valid`. They also assume that the inputs stay low while reset is held, so that the verdict and strobe checks never see a header that started before reset. The stimulus keeps within these rules. It drives `in_last` only on the final valid word and parks every input at zero during reset and between packets. It varies the idle gaps between words, the header lengths, and the packets that are sent back to back.

// File: rtl/ipv4_hdr_check.sv
module ipv4_hdr_check #(
  parameter int MAX_WORDS = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        in_last,
  output logic        fwd,
  output logic        drop,
  output logic [7:0]  new_ttl,
  output logic [15:0] new_csum,
  output logic [31:0] dst_addr,
  output logic        dst_valid,
  output logic        keep_valid,
  output logic [31:0] keep_data
);
  localparam int IDX_W = $clog2(MAX_WORDS + 1);
  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(MAX_WORDS);
  localparam logic [IDX_W-1:0] IDX_TTL = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_DST = IDX_W'(4);

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  logic [IDX_W-1:0] idx;
  logic [15:0]      acc;
  logic             bad;
  logic [3:0]       len_q;

  wire [3:0]  ver    = in_data[31:28];
  wire [3:0]  len_in = in_data[27:24];
  wire [7:0]  ttl    = in_data[31:24];
  wire        first  = (idx == '0);
  wire        over   = (idx == IDX_SAT);
  wire [15:0] sum_now = oc_add(oc_add(acc, in_data[31:16]), in_data[15:0]);

  wire word_bad = (first && (ver != 4'd4 || len_in < 4'd5)) ||
                  (idx == IDX_TTL && ttl <= 8'd1) || over;

  wire [3:0]     len_used = first ? len_in : len_q;
  wire [IDX_W:0] count    = {1'b0, idx} + 1'b1;
  wire           fail_now = bad || word_bad || (sum_now != 16'hFFFF) ||
                            (count != (IDX_W+1)'(len_used));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      acc        <= '0;
      bad        <= 1'b0;
      len_q      <= '0;
      fwd        <= 1'b0;
      drop       <= 1'b0;
      new_ttl    <= '0;
      new_csum   <= '0;
      dst_addr   <= '0;
      dst_valid  <= 1'b0;
      keep_valid <= 1'b0;
      keep_data  <= '0;
    end else begin
      fwd        <= 1'b0;
      drop       <= 1'b0;
      dst_valid  <= 1'b0;
      keep_valid <= 1'b0;
      if (in_valid) begin
        if (idx == IDX_TTL) begin
          new_ttl  <= ttl - 8'd1;
          new_csum <= oc_add(in_data[15:0], 16'h0100);
        end else begin
          keep_valid <= 1'b1;
          keep_data  <= in_data;
        end
        if (idx == IDX_DST) begin
          dst_addr  <= in_data;
          dst_valid <= 1'b1;
        end
        if (first) len_q <= len_in;
        if (in_last) begin
          fwd  <= !fail_now;
          drop <= fail_now;
          idx  <= '0;
          acc  <= '0;
          bad  <= 1'b0;
        end else begin
          acc <= sum_now;
          bad <= bad || word_bad;
          if (!over) idx <= idx + 1'b1;
        end
      end
    end
  end

  assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd && drop)) else $error("fwd and drop together");

  assert_verdict_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (fwd ^ drop)) else $error("no verdict after last word");

  assert_verdict_only_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd || drop) |-> $past(in_valid && in_last)) else $error("stray verdict");

  assert_version_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && first && ver != 4'd4) |=> drop) else $error("bad version forwarded");

  assert_fwd_ttl_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (new_ttl != 8'd0)) else $error("forwarded with dead ttl");

  assert_ttl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && idx == IDX_TTL) |=> $stable(new_ttl) && $stable(new_csum))
    else $error("ttl or checksum changed outside word 2");

  assert_dst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> !dst_valid) else $error("dst strobe longer than one cycle");
endmodule

// File: tb/test_ipv4_hdr_check.sv
`timescale 1ns/1ps
module test_ipv4_hdr_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        fwd, drop, dst_valid, keep_valid;
  logic [7:0]  new_ttl;
  logic [15:0] new_csum;
  logic [31:0] dst_addr, keep_data;

  always #2 clk = ~clk;

  ipv4_hdr_check i_ipv4_hdr_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .fwd(fwd), .drop(drop), .new_ttl(new_ttl), .new_csum(new_csum),
    .dst_addr(dst_addr), .dst_valid(dst_valid), .keep_valid(keep_valid), .keep_data(keep_data)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // behavioural reference
  logic [31:0] seen[$];
  logic        e_fwd, e_drop, e_dv, e_kv;
  logic [7:0]  e_ttl;
  logic [15:0] e_csum;
  logic [31:0] e_dst, e_kd;

  function automatic int fold(input int s);
    int r = s;
    while (r > 32'hFFFF) r = (r & 32'hFFFF) + (r >>> 16);
    return r;
  endfunction

  function automatic logic verdict_drop(input logic [31:0] q[$]);
    int s = 0;
    int len;
    if (q.size() > 15) return 1'b1;
    if (q[0][31:28] != 4'd4) return 1'b1;
    len = int'(q[0][27:24]);
    if (len < 5 || len != q.size()) return 1'b1;
    if (q[2][31:24] <= 8'd1) return 1'b1;
    foreach (q[k]) s = fold(s + int'(q[k][31:16]) + int'(q[k][15:0]));
    return s != 32'hFFFF;
  endfunction

  always @(posedge clk) begin
    e_fwd = 1'b0; e_drop = 1'b0; e_dv = 1'b0; e_kv = 1'b0;
    if (!rst_n) begin
      seen.delete();
      e_ttl = '0; e_csum = '0; e_dst = '0; e_kd = '0;
    end else if (in_valid) begin
      seen.push_back(in_data);
      if (seen.size() == 3) begin
        e_ttl  = in_data[31:24] - 8'd1;
        e_csum = 16'(fold(int'(in_data[15:0]) + 32'h100));
      end else begin
        e_kv = 1'b1; e_kd = in_data;
      end
      if (seen.size() == 5) begin
        e_dv = 1'b1; e_dst = in_data;
      end
      if (in_last) begin
        e_drop = verdict_drop(seen);
        e_fwd  = !e_drop;
        seen.delete();
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  bit past_first = 1'b0;
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n || !past_first) begin
        // R10: all outputs zero in and right after reset
        chk("R10 outputs", {fwd, drop, dst_valid, keep_valid, new_ttl, new_csum},
            {e_fwd, e_drop, e_dv, e_kv, e_ttl, e_csum});
        if (rst_n) past_first = 1'b1;
      end else begin
        chk("R8 fwd", fwd, e_fwd);
        chk("R8 drop", drop, e_drop);
        chk("R4 new_ttl", new_ttl, e_ttl);
        chk("R6 new_csum", new_csum, e_csum);
        chk("R7 dst_valid", dst_valid, e_dv);
        if (e_dv) chk("R7 dst_addr", dst_addr, e_dst);
        chk("R9 keep_valid", keep_valid, e_kv);
        if (e_kv) chk("R9 keep_data", keep_data, e_kd);
      end
    end
  end

  logic [31:0] pkt[$];

  task automatic build(input logic [3:0] ver, input logic [3:0] len, input int nwords,
                       input logic [7:0] ttl, input logic [15:0] id);
    int s = 0;
    pkt.delete();
    for (int k = 0; k < nwords; k++) begin
      case (k)
        0: pkt.push_back({ver, len, 8'h00, 16'(nwords * 4)});
        1: pkt.push_back({id, 16'h4000});
        2: pkt.push_back({ttl, 8'd17, 16'h0000});
        3: pkt.push_back(32'hC0A8_0001 + 32'(id));
        4: pkt.push_back(32'h0A00_0000 ^ {id, id});
        default: pkt.push_back({id ^ 16'(k * 16'h1357), 16'(k) * 16'hABCD});
      endcase
    end
    if (nwords >= 3) begin
      foreach (pkt[k]) s = fold(s + int'(pkt[k][31:16]) + int'(pkt[k][15:0]));
      pkt[2][15:0] = ~16'(s);
    end
  endtask

  task automatic send(input int gap);
    foreach (pkt[k]) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = pkt[k]; in_last = (k == pkt.size() - 1);
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0; in_data = 32'hDEAD_BEEF;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R1 R5: minimal valid header
    build(4'd4, 4'd5, 5, 8'd64, 16'h1234); send(0);
    // R2: version 6
    build(4'd6, 4'd5, 5, 8'd64, 16'h0001); send(0);
    // R4: ttl 1 and ttl 0 dropped, ttl 2 forwarded with new ttl 1
    build(4'd4, 4'd5, 5, 8'd1, 16'h0002); send(0);
    build(4'd4, 4'd5, 5, 8'd0, 16'h0003); send(0);
    build(4'd4, 4'd5, 5, 8'd2, 16'h0004); send(0);
    // R5: corrupted checksum; R6: near-wrap checksum 0xFF35 -> 0x0036
    build(4'd4, 4'd5, 5, 8'd64, 16'h0005); pkt[2][15:0] = 16'hFF35; send(0);
    build(4'd4, 4'd5, 5, 8'd64, 16'h0006); pkt[3][0] = ~pkt[3][0]; send(0);
    // R3: length mismatch, length below 5, too many words, full 15 words
    build(4'd4, 4'd6, 5, 8'd64, 16'h0007); send(0);
    build(4'd4, 4'd4, 4, 8'd64, 16'h0008); send(0);
    build(4'd4, 4'd15, 16, 8'd64, 16'h0009); send(0);
    build(4'd4, 4'd15, 15, 8'd64, 16'h000A); send(0);
    build(4'd4, 4'd8, 8, 8'd200, 16'h000B); send(0);
    // R3: one-word and two-word fragments
    build(4'd4, 4'd5, 1, 8'd64, 16'h000C); send(0);
    build(4'd4, 4'd5, 2, 8'd64, 16'h000D); send(0);
    // R11: idle gaps between words
    build(4'd4, 4'd7, 7, 8'd9, 16'h000E); send(2);
    build(4'd6, 4'd5, 5, 8'd9, 16'h000F); send(1);
    // R1: many packets with varied identifiers and lengths
    for (int n = 0; n < 40; n++) begin
      build(4'd4, 4'(5 + n % 11), 5 + n % 11, 8'(n * 7 + 3), 16'(n * 16'h2F1B)); send(n % 3);
    end
    repeat (4) @(posedge clk);
    done = 1'b1;
    summary();
  end
endmodule